// File: doc/BRIEF.md
# Remote DMA Latch Port Sequencer

This block moves a run of words between a host and local buffer memory through an external data latch, one word per handshake. Software loads a start address, a byte count and a direction, then pulses `start_i`. While `port_req_o` is high the block waits for the host side to service the latch.

For a host-to-local transfer, the host fills the latch and raises `wr_ack_i`. The block then runs one local memory write cycle, and during that cycle `latch_oe_o` puts the latch contents onto the local bus. For a local-to-host transfer, the block prefetches a word with a local memory read cycle. In the last cycle of that read it strobes the word into the latch with `latch_stb_o`. It then requests service and waits for `rd_ack_i` before it reads the next word.

The address rises by `WORD_BYTES` with each word and the remaining count falls by the same amount. When the count runs out, the block drops its request and raises a completion flag. Both acknowledges come from another clock domain. Each one passes through a two-flop synchronizer and only its rising edge is used.

Top module: `rdma_latch_port`

## Requirements
- R1: After reset `port_req_o`, `latch_oe_o`, `latch_stb_o`, `mem_rd_o`, `mem_wr_o`, `busy_o` and `done_o` are all low.
- R2: On a host-to-local transfer (`remote_wr_i`=1), `port_req_o` is high while the block waits. After a `wr_ack_i` rising edge, the block runs one memory cycle of `CYC_LEN` clocks, and both `mem_wr_o` and `latch_oe_o` are high for the whole cycle.
- R3: On a local-to-host transfer (`remote_wr_i`=0), a read cycle of `CYC_LEN` clocks with `mem_rd_o` high starts right after start. `latch_stb_o` is high only in the final clock of each read cycle, and `port_req_o` goes high as soon as the read cycle ends.
- R4: During a local-to-host transfer, no new read cycle begins until a `rd_ack_i` rising edge arrives. After that edge, the next word is read if bytes remain.
- R5: The first memory cycle uses `start_addr_i`. Each later word's address is the previous one plus `WORD_BYTES`, wrapping modulo 2^AW. `mem_addr_o` is stable through a memory cycle.
- R6: A transfer of N bytes makes ceil(N/`WORD_BYTES`) memory cycles. A local-to-host transfer ends at the acknowledge of its last word. At the end, `port_req_o` and `busy_o` drop and `done_o` rises. `done_o` stays high until the next accepted start.
- R7: A start with `byte_cnt_i`=0 makes no memory cycle and no request, and it raises `done_o` on the next clock.
- R8: Each acknowledge is counted only on its rising edge after synchronization. An acknowledge held high moves exactly one word.
- R9: A `start_i` pulse while `busy_o` is high is ignored, and the running transfer keeps its address sequence and word count.
- R10: `mem_rd_o` and `mem_wr_o` are never high together, and `port_req_o` is low during any memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| remote_wr_i | input | 1 | 1: host-to-local, 0: local-to-host |
| start_addr_i | input | AW | First local memory address |
| byte_cnt_i | input | CW | Bytes to move |
| wr_ack_i | input | 1 | Host filled the latch (asynchronous) |
| rd_ack_i | input | 1 | Host emptied the latch (asynchronous) |
| port_req_o | output | 1 | Request for host service of the latch |
| latch_oe_o | output | 1 | Drives latch contents onto local bus |
| latch_stb_o | output | 1 | Loads local bus data into latch |
| mem_rd_o | output | 1 | Local memory read cycle |
| mem_wr_o | output | 1 | Local memory write cycle |
| mem_addr_o | output | AW | Local memory address |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky completion flag |

## Verification
The bench builds the block with AW=8, CW=5, WORD_BYTES=2 and CYC_LEN=3. These values make every byte count from 0 to 12 in both directions cheap to run, including odd counts that round up to a whole word. A start address near 0xFF makes the address wrap. A three-clock memory cycle puts the latch strobe at a position different from the first clock. Extra runs hold an acknowledge high, delay a read acknowledge, and pulse start during a busy transfer.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WR_WAIT = 3'd1,
    ST_WR_CYC  = 3'd2,
    ST_RD_CYC  = 3'd3,
    ST_RD_WAIT = 3'd4
  } rdma_state_e;
endpackage

// File: rtl/rdma_sync_edge.sv
module rdma_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], async_i};
  end

  // sh_q[1] is the second synchronizer stage, sh_q[2] its delayed copy
  assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/rdma_cyc_timer.sv
module rdma_cyc_timer #(
  parameter int unsigned CYC_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic last_o
);
  localparam int unsigned TW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [TW-1:0] LAST_V = TW'(CYC_LEN - 1);

  logic [TW-1:0] cnt_q;

  assign last_o = en_i && (cnt_q == LAST_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rdma_addr_cnt.sv
module rdma_addr_cnt #(
  parameter int unsigned AW         = 16,
  parameter int unsigned CW         = 16,
  parameter int unsigned WORD_BYTES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] addr_o,
  output logic          last_word_o,
  output logic          empty_o
);
  localparam logic [CW-1:0] WB_C = CW'(WORD_BYTES);
  localparam logic [AW-1:0] WB_A = AW'(WORD_BYTES);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;

  assign last_word_o = (cnt_q <= WB_C);
  assign empty_o     = (cnt_q == '0);
  assign addr_o      = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      cnt_q  <= cnt_i;
    end else if (step_i) begin
      addr_q <= addr_q + WB_A;
      cnt_q  <= last_word_o ? '0 : cnt_q - WB_C;
    end
  end
endmodule

// File: rtl/rdma_port_fsm.sv
module rdma_port_fsm
  import rdma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic remote_wr_i,
  input  logic cnt_zero_i,
  input  logic wr_rise_i,
  input  logic rd_rise_i,
  input  logic cyc_last_i,
  input  logic last_word_i,
  input  logic empty_i,
  output logic load_o,
  output logic step_o,
  output logic cyc_en_o,
  output logic port_req_o,
  output logic latch_oe_o,
  output logic latch_stb_o,
  output logic mem_rd_o,
  output logic mem_wr_o,
  output logic busy_o,
  output logic done_o
);
  rdma_state_e st_q, st_d;
  logic done_q, set_done, clr_done;

  always_comb begin
    st_d     = st_q;
    load_o   = 1'b0;
    step_o   = 1'b0;
    set_done = 1'b0;
    clr_done = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        clr_done = 1'b1;
        if (cnt_zero_i) set_done = 1'b1;
        else begin
          load_o = 1'b1;
          st_d   = remote_wr_i ? ST_WR_WAIT : ST_RD_CYC;
        end
      end
      ST_WR_WAIT: if (wr_rise_i) st_d = ST_WR_CYC;
      ST_WR_CYC: if (cyc_last_i) begin
        step_o = 1'b1;
        if (last_word_i) begin
          set_done = 1'b1;
          st_d     = ST_IDLE;
        end else st_d = ST_WR_WAIT;
      end
      ST_RD_CYC: if (cyc_last_i) begin
        step_o = 1'b1;
        st_d   = ST_RD_WAIT;
      end
      ST_RD_WAIT: if (rd_rise_i) begin
        if (empty_i) begin
          set_done = 1'b1;
          st_d     = ST_IDLE;
        end else st_d = ST_RD_CYC;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (set_done)      done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
    end
  end

  assign cyc_en_o    = (st_q == ST_WR_CYC) || (st_q == ST_RD_CYC);
  assign mem_wr_o    = (st_q == ST_WR_CYC);
  assign mem_rd_o    = (st_q == ST_RD_CYC);
  assign latch_oe_o  = (st_q == ST_WR_CYC);
  assign latch_stb_o = (st_q == ST_RD_CYC) && cyc_last_i;
  assign port_req_o  = (st_q == ST_WR_WAIT) || (st_q == ST_RD_WAIT);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
endmodule

// File: rtl/rdma_latch_port.sv
module rdma_latch_port #(
  parameter int unsigned AW         = 16,
  parameter int unsigned CW         = 16,
  parameter int unsigned WORD_BYTES = 2,
  parameter int unsigned CYC_LEN    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          remote_wr_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] byte_cnt_i,
  input  logic          wr_ack_i,
  input  logic          rd_ack_i,
  output logic          port_req_o,
  output logic          latch_oe_o,
  output logic          latch_stb_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int unsigned NACK = 2;

  logic [NACK-1:0] ack_raw, ack_rise;
  logic load, step, cyc_en, cyc_last, last_word, empty;

  assign ack_raw = {rd_ack_i, wr_ack_i};

  for (genvar g = 0; g < NACK; g++) begin : g_ack
    rdma_sync_edge u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(ack_raw[g]),
      .rise_o (ack_rise[g])
    );
  end

  rdma_cyc_timer #(.CYC_LEN(CYC_LEN)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cyc_en),
    .last_o(cyc_last)
  );

  rdma_addr_cnt #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .addr_i     (start_addr_i),
    .cnt_i      (byte_cnt_i),
    .addr_o     (mem_addr_o),
    .last_word_o(last_word),
    .empty_o    (empty)
  );

  rdma_port_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .remote_wr_i(remote_wr_i),
    .cnt_zero_i (byte_cnt_i == '0),
    .wr_rise_i  (ack_rise[0]),
    .rd_rise_i  (ack_rise[1]),
    .cyc_last_i (cyc_last),
    .last_word_i(last_word),
    .empty_i    (empty),
    .load_o     (load),
    .step_o     (step),
    .cyc_en_o   (cyc_en),
    .port_req_o (port_req_o),
    .latch_oe_o (latch_oe_o),
    .latch_stb_o(latch_stb_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/rdma_latch_port_chk.sv
module rdma_latch_port_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          port_req_o,
  input logic          latch_oe_o,
  input logic          latch_stb_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          busy_o,
  input logic          done_o
);
  // R10
  excl_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  // R10
  req_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> !port_req_o);
  // R2
  latch_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_oe_o |-> mem_wr_o);
  // R3
  stb_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_stb_o |-> mem_rd_o);
  // R3
  stb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_stb_o |=> !latch_stb_o);
  // R3
  rd_then_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_rd_o) |-> port_req_o);
  // R5
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_rd_o || mem_wr_o) && $past(mem_rd_o || mem_wr_o)) |-> $stable(mem_addr_o));
  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R6
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
endmodule

bind rdma_latch_port rdma_latch_port_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .port_req_o (port_req_o),
  .latch_oe_o (latch_oe_o),
  .latch_stb_o(latch_stb_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_addr_o (mem_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/rdma_latch_port_tb.sv
module rdma_latch_port_tb;
  localparam int AW = 8, CW = 5, WB = 2, CYC = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, remote_wr_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [CW-1:0] byte_cnt_i = '0;
  logic wr_ack_i = 1'b0, rd_ack_i = 1'b0;
  logic port_req_o, latch_oe_o, latch_stb_o, mem_rd_o, mem_wr_o, busy_o, done_o;
  logic [AW-1:0] mem_addr_o;

  int checks = 0, errors = 0;
  int run = 0, words = 0;
  logic [AW-1:0] exp_addr = '0;
  bit stb_bad = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rdma_latch_port #(.AW(AW), .CW(CW), .WORD_BYTES(WB), .CYC_LEN(CYC)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Memory cycle monitor: R2 R3 R5
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_rd_o || mem_wr_o) begin
        if (run == 0) chk(mem_addr_o == exp_addr, "R5 addr", int'(mem_addr_o), int'(exp_addr));
        if (latch_oe_o != mem_wr_o) stb_bad = 1'b1;
        if (latch_stb_o != (mem_rd_o && run == CYC - 1)) stb_bad = 1'b1;
        run++;
      end else begin
        if (latch_oe_o || latch_stb_o) stb_bad = 1'b1;
        if (run != 0) begin
          chk(run == CYC, "R2/R3 cycle length", run, CYC);
          chk(!stb_bad, "R2/R3 latch strobes", int'(stb_bad), 0);
          stb_bad = 1'b0;
          words++;
          exp_addr = exp_addr + AW'(WB);
          run = 0;
        end
      end
    end
  end

  task automatic pulse_ack(input bit wr);
    if (wr) wr_ack_i = 1'b1; else rd_ack_i = 1'b1;
    repeat (4) @(negedge clk_i);
    wr_ack_i = 1'b0; rd_ack_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic kick(input bit wr, input int addr, input int cnt);
    remote_wr_i = wr; start_addr_i = AW'(addr); byte_cnt_i = CW'(cnt);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic finish_xfer(input bit wr);
    while (!done_o) begin
      @(negedge clk_i);
      if (port_req_o) pulse_ack(wr);
    end
  endtask

  task automatic check_end(input int cnt);
    int exp_w = (cnt + WB - 1) / WB;
    chk(words == exp_w, "R6 word count", words, exp_w);
    chk(done_o && !busy_o && !port_req_o, "R6 done state",
        {done_o, busy_o, port_req_o}, 3'b100);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk({port_req_o, latch_oe_o, latch_stb_o, mem_rd_o, mem_wr_o, busy_o, done_o} == 7'd0,
        "R1 reset outputs", {port_req_o, latch_oe_o, latch_stb_o, mem_rd_o, mem_wr_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // Sweep: both directions, counts 0..12, wrapping addresses (R2 R3 R5 R6 R7)
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c <= 12; c++) begin
        int a = (c * 37 + 250 + d * 3) % 256;
        words = 0; exp_addr = AW'(a);
        kick(d[0], a, c);
        if (c == 0) begin
          // R7
          chk(done_o && !busy_o && !port_req_o, "R7 zero count done",
              {done_o, busy_o, port_req_o}, 3'b100);
          repeat (4) @(negedge clk_i);
          chk(words == 0, "R7 no memory cycle", words, 0);
        end else begin
          chk(!done_o && busy_o, "R6 done cleared on start", done_o, 0);
          if (d == 0) begin
            // R3: read starts with no acknowledge
            repeat (CYC + 2) @(negedge clk_i);
            chk(words == 1 && port_req_o, "R3 prefetch then request", words, 1);
          end
          finish_xfer(d == 1);
          check_end(c);
        end
        repeat (3) @(negedge clk_i);
      end
    end

    // R8: write acknowledge held high moves exactly one word
    words = 0; exp_addr = 8'h40;
    kick(1'b1, 8'h40, 6);
    wr_ack_i = 1'b1;
    repeat (30) @(negedge clk_i);
    chk(words == 1 && port_req_o, "R8 held ack one word", words, 1);
    wr_ack_i = 1'b0;
    repeat (4) @(negedge clk_i);
    finish_xfer(1'b1);
    check_end(6);
    repeat (3) @(negedge clk_i);

    // R4: no refill until read acknowledge; R9: start during busy ignored
    words = 0; exp_addr = 8'h80;
    kick(1'b0, 8'h80, 7);
    repeat (25) @(negedge clk_i);
    chk(words == 1 && port_req_o, "R4 wait for read ack", words, 1);
    kick(1'b1, 8'h11, 2);
    repeat (3) @(negedge clk_i);
    chk(words == 1 && port_req_o, "R9 start ignored while busy", words, 1);
    pulse_ack(1'b0);
    repeat (CYC + 2) @(negedge clk_i);
    chk(words == 2 && port_req_o, "R4 refill after ack", words, 2);
    finish_xfer(1'b0);
    check_end(7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule